// File: doc/BRIEF.md
# Two-Wire Serial Configuration Memory Slave

This block is the slave side of a two-wire serial configuration memory. While the active-low serial-enable input keeps it in access mode, it oversamples the serial clock and the bidirectional data line with the system clock. It detects start and stop conditions and compares the incoming device address byte with its own. After a write header it takes in a three-byte memory address. It then either stores data bytes into an internal byte array or streams bytes back out of it. It drives the data line only by pulling it low, through an output-enable. An external pull-up supplies the high level.

An internal address counter is kept across transactions. A master can therefore run a current-address read with no address phase at all. It can also load the counter with an aborted write header and issue a repeated start to perform a random read. Each acknowledged byte continues a sequential read. One reserved address returns a fixed pair of identification bytes in place of array contents. The array size and the page size are parameters.

Top module: `cfgmem_serial_slave`

## Requirements
- R1: After reset the slave releases the data line (`sda_oe` = 0) and waits in idle for a start condition.
- R2: The device address byte is shifted in most significant bit first. Its upper seven bits must equal `DEV_ADDR` (default 0x50). Its bit 0 selects the operation: 1 for read, 0 for write. On a match the slave pulls the line low during the ninth (acknowledge) clock.
- R3: After a write device address, exactly three address bytes follow, most significant bit first, in the order high, middle, low. The slave acknowledges each of them and loads the counter once the low byte has arrived.
- R4: Any further bytes in a write are data. They are shifted least significant bit first, acknowledged, and stored at the counter address, after which the counter advances.
- R5: A random read returns the byte at the loaded address. The read is an address-only write header, a repeated start, then a read device address. Data is sent least significant bit first.
- R6: When the master acknowledges a byte, the slave sends the next byte. When the master does not acknowledge, the slave releases the line and drives nothing more until the next start condition.
- R7: The counter persists between transactions. A current-address read returns the byte that follows the last one read or written.
- R8: On a write, the counter advances only within the current page (`PAGE_AW` low bits). After the last byte of a page it returns to the first byte of the same page.
- R9: On a read, the counter advances through the whole array. After the last array byte it wraps to address 0 and keeps sending.
- R10: Loading address 0x040000 selects identification readback. A read then returns 0x1E, then 0xF7, and keeps alternating between the two while the master acknowledges.
- R11: Any other loaded address is reduced to its low `ARRAY_AW` bits.
- R12: If the device address does not match, the slave does not acknowledge and keeps the line released until the next start condition.
- R13: While `ser_en_n` is high, the slave aborts any transfer, releases the line within one clock, and ignores the bus. The address counter keeps its value. Once `ser_en_n` is low again, a new start condition is served normally.
- R14: The slave switches its line drive on only after it has detected a falling edge of the serial clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en_n | input | 1 | Low keeps the slave in two-wire access mode |
| scl_i | input | 1 | Serial clock from the master |
| sda_i | input | 1 | Sensed level of the data line |
| sda_oe | output | 1 | High pulls the data line low |

## Verification
The hardest states to reach are those that depend on a counter value left behind by an earlier transaction. These are a page rollover on write, a read that wraps from the last array byte to address 0, and an abort through serial-enable in the middle of a byte. The bench first fills the whole array with page writes, so every later read has a known expected byte. It then performs short writes at the end of a page and random reads near the top of the array. A behavioural address model predicts each byte across those transaction boundaries. The abort is raised during the low phase of the serial clock, partway through a byte that the slave is sending. A following current-address read then shows that the counter did not move.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;
  localparam int ADDR_BYTES = 3;
  localparam int LOAD_W = ADDR_BYTES * 8;
  localparam logic [LOAD_W-1:0] ID_LOC = 24'h040000;
  localparam logic [7:0] ID_BYTE_A = 8'h1E;
  localparam logic [7:0] ID_BYTE_B = 8'hF7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADR,
    ST_WDAT,
    ST_RDAT,
    ST_SKIP
  } link_st_e;
endpackage

// File: rtl/cfgmem_sync_detect.sv
module cfgmem_sync_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  // data edges while the clock stays high
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/cfgmem_addr_ctr.sv
module cfgmem_addr_ctr
  import cfgmem_pkg::*;
#(
  parameter int AW = 8,
  parameter int PW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [LOAD_W-1:0] load_addr,
  input  logic              rd_step,
  input  logic              wr_step,
  output logic [AW-1:0]     cur_addr,
  output logic              id_mode,
  output logic              id_sel
);
  logic [AW-1:0] addr_q, addr_n;
  logic id_q, id_n, sel_q, sel_n;

  always_comb begin
    addr_n = addr_q;
    id_n   = id_q;
    sel_n  = sel_q;
    if (load_en) begin
      if (load_addr == ID_LOC) begin
        id_n  = 1'b1;
        sel_n = 1'b0;
      end else begin
        id_n   = 1'b0;
        addr_n = load_addr[AW-1:0];
      end
    end else if (rd_step) begin
      if (id_q) sel_n = ~sel_q;
      else      addr_n = addr_q + 1'b1;
    end else if (wr_step && !id_q) begin
      addr_n = {addr_q[AW-1:PW], addr_q[PW-1:0] + 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      id_q   <= 1'b0;
      sel_q  <= 1'b0;
    end else if (load_en || rd_step || wr_step) begin
      addr_q <= addr_n;
      id_q   <= id_n;
      sel_q  <= sel_n;
    end
  end

  assign cur_addr = addr_q;
  assign id_mode  = id_q;
  assign id_sel   = sel_q;

  // R8: write stepping never leaves the page
  assert_page_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_step && !load_en && !id_q) |=> (addr_q[AW-1:PW] == $past(addr_q[AW-1:PW])));

  // R9: read stepping past the top returns to zero
  assert_array_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_step && !load_en && !id_q && (addr_q == {AW{1'b1}})) |=> (addr_q == '0));
endmodule

// File: rtl/cfgmem_byte_store.sv
module cfgmem_byte_store #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/cfgmem_link_fsm.sv
module cfgmem_link_fsm
  import cfgmem_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_en_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [7:0]        tx_byte,
  output logic              sda_oe,
  output logic              load_en,
  output logic [LOAD_W-1:0] load_addr,
  output logic              rd_step,
  output logic              wr_step,
  output logic              wr_pulse,
  output logic [7:0]        wr_data
);
  link_st_e st_q, st_n;
  logic [3:0]  cnt_q, cnt_n;
  logic [7:0]  sh_q, sh_n, tx_q, tx_n;
  logic [15:0] ab_q, ab_n;
  logic [1:0]  idx_q, idx_n;
  logic        oe_q, oe_n, mack_q, mack_n;

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; sh_n = sh_q; tx_n = tx_q;
    ab_n = ab_q; idx_n = idx_q; oe_n = oe_q; mack_n = mack_q;
    load_en = 1'b0; rd_step = 1'b0; wr_step = 1'b0; wr_pulse = 1'b0;
    if (ser_en_n) begin
      st_n = ST_IDLE; oe_n = 1'b0; cnt_n = '0;
    end else if (start_ev) begin
      st_n = ST_DEV; oe_n = 1'b0; cnt_n = '0;
    end else if (stop_ev) begin
      st_n = ST_IDLE; oe_n = 1'b0; cnt_n = '0;
    end else if (scl_rise && st_q != ST_IDLE && st_q != ST_SKIP && cnt_q < 4'd9) begin
      cnt_n = cnt_q + 4'd1;
      if (st_q == ST_RDAT) begin
        if (cnt_q == 4'd8) begin
          mack_n  = ~sda_s;
          rd_step = 1'b1;
        end
      end else if (cnt_q < 4'd8) begin
        if (st_q == ST_WDAT) sh_n = {sda_s, sh_q[7:1]};
        else                 sh_n = {sh_q[6:0], sda_s};
      end
    end else if (scl_fall) begin
      unique case (st_q)
        ST_DEV, ST_ADR, ST_WDAT: begin
          if (cnt_q == 4'd8) begin
            if (st_q == ST_DEV && sh_q[7:1] != DEV_ADDR) begin
              st_n = ST_SKIP; cnt_n = '0;
            end else begin
              oe_n = 1'b1;
            end
            if (st_q == ST_WDAT) begin
              wr_pulse = 1'b1;
              wr_step  = 1'b1;
            end
            if (st_q == ST_ADR) begin
              if (idx_q == 2'd0) ab_n[15:8] = sh_q;
              if (idx_q == 2'd1) ab_n[7:0]  = sh_q;
              if (idx_q == 2'd2) load_en    = 1'b1;
            end
          end else if (cnt_q == 4'd9) begin
            oe_n = 1'b0; cnt_n = '0;
            if (st_q == ST_DEV) begin
              if (sh_q[0]) begin
                st_n = ST_RDAT; tx_n = tx_byte; oe_n = ~tx_byte[0];
              end else begin
                st_n = ST_ADR; idx_n = 2'd0;
              end
            end else if (st_q == ST_ADR) begin
              if (idx_q == 2'd2) st_n = ST_WDAT;
              else               idx_n = idx_q + 2'd1;
            end
          end
        end
        ST_RDAT: begin
          if (cnt_q >= 4'd1 && cnt_q <= 4'd7) begin
            oe_n = ~tx_q[cnt_q[2:0]];
          end else if (cnt_q == 4'd8) begin
            oe_n = 1'b0;
          end else if (cnt_q == 4'd9) begin
            cnt_n = '0;
            if (mack_q) begin
              tx_n = tx_byte; oe_n = ~tx_byte[0];
            end else begin
              st_n = ST_SKIP; oe_n = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; tx_q <= '0;
      ab_q <= '0; idx_q <= '0; oe_q <= 1'b0; mack_q <= 1'b0;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; sh_q <= sh_n; tx_q <= tx_n;
      ab_q <= ab_n; idx_q <= idx_n; oe_q <= oe_n; mack_q <= mack_n;
    end
  end

  assign sda_oe    = oe_q;
  assign load_addr = {ab_q, sh_q};
  assign wr_data   = sh_q;

  // R13: serial-enable high frees the line on the next clock
  assert_release_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en_n |=> !sda_oe);

  // R14: drive turns on only after a detected clock fall
  assert_drive_on_fall_R14: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R12: an unaddressed or finished slave stays off the line
  assert_skip_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SKIP) |-> !sda_oe);
endmodule

// File: rtl/cfgmem_serial_slave.sv
module cfgmem_serial_slave
  import cfgmem_pkg::*;
#(
  parameter int ARRAY_AW = 8,
  parameter int PAGE_AW = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_en_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic load_en, rd_step, wr_step, wr_pulse, id_mode, id_sel;
  logic [LOAD_W-1:0] load_addr;
  logic [ARRAY_AW-1:0] cur_addr;
  logic [7:0] wr_data, rd_data, tx_byte;

  cfgmem_sync_detect #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  cfgmem_link_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ser_en_n(ser_en_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .tx_byte(tx_byte), .sda_oe(sda_oe), .load_en(load_en), .load_addr(load_addr),
    .rd_step(rd_step), .wr_step(wr_step), .wr_pulse(wr_pulse), .wr_data(wr_data)
  );

  cfgmem_addr_ctr #(.AW(ARRAY_AW), .PW(PAGE_AW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .rd_step(rd_step), .wr_step(wr_step), .cur_addr(cur_addr),
    .id_mode(id_mode), .id_sel(id_sel)
  );

  cfgmem_byte_store #(.AW(ARRAY_AW)) u_store (
    .clk(clk), .wr_en(wr_pulse & ~id_mode), .wr_addr(cur_addr), .wr_data(wr_data),
    .rd_addr(cur_addr), .rd_data(rd_data)
  );

  assign tx_byte = id_mode ? (id_sel ? ID_BYTE_B : ID_BYTE_A) : rd_data;
endmodule

// File: tb/cfgmem_serial_slave_bench.sv
module cfgmem_serial_slave_bench;
  localparam int Q = 10;
  localparam logic [6:0] DEV = 7'h50;

  logic clk, rst_n, ser_en_n, scl, m_low;
  logic sda_oe;
  wire  sda_line = !(m_low || sda_oe);

  int n_chk, n_err, mon_chk, mon_err;
  logic exp_win, exp_oe;
  string exp_req;

  logic [7:0] mdl_mem [256];
  int mdl_ptr;
  bit mdl_id, mdl_sel;

  cfgmem_serial_slave u_cfgmem_serial_slave (
    .clk(clk), .rst_n(rst_n), .ser_en_n(ser_en_n),
    .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (exp_win) begin
      mon_chk++;
      if (sda_oe !== exp_oe) begin
        mon_err++;
        if (mon_err < 20)
          $display("FAIL %s line drive actual=%0b expected=%0b", exp_req, sda_oe, exp_oe);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err + mon_err + 1, n_chk + mon_chk + 1);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // model of the counter, built from the requirements
  task automatic mdl_load(input int a);
    if (a == 32'h040000) begin mdl_id = 1; mdl_sel = 0; end
    else begin mdl_id = 0; mdl_ptr = a & 255; end
  endtask
  function automatic logic [7:0] mdl_peek();
    if (mdl_id) return mdl_sel ? 8'hF7 : 8'h1E;
    return mdl_mem[mdl_ptr];
  endfunction
  task automatic mdl_rd_step();
    if (mdl_id) mdl_sel = !mdl_sel;
    else mdl_ptr = (mdl_ptr + 1) & 255;
  endtask
  task automatic mdl_write(input logic [7:0] b);
    if (!mdl_id) begin
      mdl_mem[mdl_ptr] = b;
      mdl_ptr = (mdl_ptr & ~15) | ((mdl_ptr + 1) & 15);
    end
  endtask

  task automatic bit_slot(input bit drv_low, input bit exp_drv, input string req, output bit line);
    wait_n(Q/2); m_low = drv_low;
    wait_n(Q/2); scl = 1'b1;
    exp_oe = exp_drv; exp_req = req; exp_win = 1'b1;
    wait_n(Q/2); line = sda_line;
    wait_n(Q/2); exp_win = 1'b0; scl = 1'b0;
  endtask

  task automatic bstart();
    wait_n(Q/2); m_low = 1'b0;
    wait_n(Q/2); scl = 1'b1;
    wait_n(Q/2); m_low = 1'b1;
    wait_n(Q/2); scl = 1'b0;
  endtask

  task automatic bstop();
    wait_n(Q/2); m_low = 1'b1;
    wait_n(Q/2); scl = 1'b1;
    wait_n(Q/2); m_low = 1'b0;
    wait_n(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit lsb_first, input bit exp_ack, input string req);
    bit l;
    for (int i = 0; i < 8; i++) bit_slot(!b[lsb_first ? i : 7 - i], 1'b0, req, l);
    bit_slot(1'b0, exp_ack, req, l);
    check(l == !exp_ack, {req, " acknowledge"}, l, !exp_ack);
  endtask

  task automatic recv_byte(input bit m_ack, input string req);
    logic [7:0] expv, got;
    bit l;
    expv = mdl_peek();
    for (int i = 0; i < 8; i++) begin
      bit_slot(1'b0, !expv[i], req, l);
      got[i] = l;
    end
    bit_slot(m_ack, 1'b0, req, l);
    check(got == expv, {req, " read byte"}, got, expv);
    mdl_rd_step();
  endtask

  task automatic set_ptr(input int a, input string req);
    bstart();
    send_byte({DEV, 1'b0}, 0, 1, req);
    send_byte(a[23:16], 0, 1, req);
    send_byte(a[15:8], 0, 1, req);
    send_byte(a[7:0], 0, 1, req);
    mdl_load(a);
  endtask

  task automatic read_run(input int n, input bit do_stop, input string req);
    bstart();
    send_byte({DEV, 1'b1}, 0, 1, req);
    for (int k = 0; k < n; k++) recv_byte(k < n - 1, req);
    if (do_stop) bstop();
  endtask

  task automatic write_run(input int a, input int n, input int seed, input string req);
    logic [7:0] b;
    set_ptr(a, req);
    for (int k = 0; k < n; k++) begin
      b = 8'((a + k) * 37 + seed);
      send_byte(b, 1, 1, req);
      mdl_write(b);
    end
    bstop();
  endtask

  task automatic quiet_slots(input int n, input string req);
    bit l;
    for (int i = 0; i < n; i++) begin
      bit_slot(1'b0, 1'b0, req, l);
      check(l == 1'b1, {req, " line released"}, l, 1);
    end
  endtask

  initial begin
    bit l;
    logic [7:0] e;
    n_chk = 0; n_err = 0; mon_chk = 0; mon_err = 0;
    exp_win = 0; exp_oe = 0; exp_req = "";
    mdl_ptr = 0; mdl_id = 0; mdl_sel = 0;
    rst_n = 1'b0; ser_en_n = 1'b0; scl = 1'b1; m_low = 1'b0;
    wait_n(5);
    check(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);
    rst_n = 1'b1;
    wait_n(5);
    check(sda_oe == 1'b0, "R1 idle release", sda_oe, 0);
    scl = 1'b1;

    // R3 R4: fill the array page by page
    for (int p = 0; p < 16; p++) write_run(p * 16, 16, 11, "R4 page fill");

    // R5 R6: random read with sequential continuation
    set_ptr(5, "R5 header");
    read_run(4, 1, "R5 random sequential");
    // R7: current address continues from last read
    read_run(2, 1, "R7 current address");
    // R6: after a missing acknowledge the slave stays off the line
    read_run(1, 0, "R6 no-ack end");
    quiet_slots(9, "R6 after no-ack");
    bstop();

    // R8: write wraps inside page 2
    write_run(8'h2E, 4, 99, "R8 page wrap write");
    set_ptr(8'h20, "R8 header");
    read_run(2, 1, "R8 wrapped bytes");
    set_ptr(8'h2E, "R8 header");
    read_run(3, 1, "R9 read crosses page");
    write_run(8'h3F, 1, 5, "R8 last of page");
    read_run(1, 1, "R8 counter after page end");

    // R9: read wraps at the top of the array
    set_ptr(8'hFE, "R9 header");
    read_run(3, 1, "R9 array wrap");

    // R10: identification bytes
    set_ptr(32'h040000, "R10 header");
    e = mdl_peek();
    check(e == 8'h1E, "R10 model first id", e, 8'h1E);
    read_run(3, 1, "R10 id readback");

    // R11: high address bits dropped
    set_ptr(32'h012305, "R11 header");
    read_run(1, 1, "R11 masked address");

    // R12: foreign device address
    bstart();
    send_byte({7'h51, 1'b1}, 0, 0, "R12 mismatch");
    quiet_slots(9, "R12 mismatch");
    bstop();
    read_run(1, 1, "R12 counter untouched");

    // R13: serial-enable abort mid-byte
    set_ptr(8'h10, "R13 header");
    bstart();
    send_byte({DEV, 1'b1}, 0, 1, "R13 read start");
    e = mdl_peek();
    for (int i = 0; i < 3; i++) bit_slot(1'b0, !e[i], "R13 partial", l);
    wait_n(Q/2);
    ser_en_n = 1'b1;
    wait_n(2);
    check(sda_oe == 1'b0, "R13 abort release", sda_oe, 0);
    bstop();
    bstart();
    send_byte({DEV, 1'b1}, 0, 0, "R13 disabled no ack");
    quiet_slots(9, "R13 disabled");
    bstop();
    ser_en_n = 1'b0;
    wait_n(4);
    read_run(2, 1, "R13 resume counter kept");

    // R2: write device header acknowledged after resume
    bstart();
    send_byte({DEV, 1'b0}, 0, 1, "R2 write header");
    bstop();

    wait_n(10);
    $display("Result: errors=%0d of %0d checks", n_err + mon_err, n_chk + mon_chk);
    $finish;
  end
endmodule